// File: doc/BRIEF.md
# Delay-Slot Next-PC Sequencer with Likely-Branch Annul

This block decides where a simple in-order 32-bit core fetches next, one retired instruction at a time. It holds the program counter, classifies the retiring instruction by its primary opcode, and compares the two register operand values. From these it computes the next PC, and it keeps a one-entry record of a branch or jump target that is owed after the delay slot.

Ordinary equal and not-equal branches and direct jumps always let their single delay-slot instruction run. The target is then applied on the following retire. The likely variant of branch-on-equal differs only when it is not taken. In that case the slot is annulled by stepping the PC straight over it, so the slot is never fetched and can change no register. A `squash` strobe marks that retire.

The block also flags opcodes outside its accepted set, for use by a trap path elsewhere in the core. A parameter can remove the likely variant, so that its opcode becomes unsupported.

Top module: `dslot_npc_seq`

## Requirements
- R1: While reset is asserted and after it is released, `pc` equals the boot vector 32'hBFC00000, `slot_pend` is 0, and `squash` is 0 until a retire.
- R2: The opcode is `instr[31:26]`. The following opcodes are accepted with `bad_op` = 0: 6'h00, 6'h08 to 6'h0F, 6'h23 and 6'h2B (sequential), 6'h02 and 6'h03 (jump), 6'h04 (branch-equal), 6'h05 (branch-not-equal), and 6'h14 (likely branch-equal, when `LIKELY_EN` = 1). Any other opcode gives `bad_op` = 1.
- R3: A retiring branch is taken when `rs_val == rt_val` for 6'h04 and 6'h14, and when they differ for 6'h05. A taken branch sets `pc` to pc+4 and `slot_pend` to 1. It sets `slot_tgt` to pc+4 plus the sign-extended `instr[15:0]` shifted left by 2.
- R4: A retiring jump sets `pc` to pc+4 and `slot_pend` to 1. It sets `slot_tgt` to the top 4 bits of pc+4, followed by `instr[25:0]`, followed by two zero bits.
- R5: A retire with `slot_pend` = 1 loads `pc` from `slot_tgt` and clears `slot_pend`. A branch or jump in that delay slot has no effect on the PC.
- R6: A not-taken likely branch drives `squash` = 1 during its retire cycle. It moves `pc` to pc+8 and leaves `slot_pend` at 0, so the delay-slot instruction is never fetched.
- R7: A not-taken branch-equal or branch-not-equal moves `pc` to pc+4 with `squash` = 0. Its delay slot then executes and falls through to pc+8.
- R8: With `retire` low, `pc`, `slot_pend` and `slot_tgt` hold their values and `squash` is 0.
- R9: With `LIKELY_EN` = 0, opcode 6'h14 gives `bad_op` = 1 and advances `pc` by 4 with no pending target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire | input | 1 | The presented instruction retires on this edge |
| instr | input | 32 | Instruction word at `pc` |
| rs_val | input | 32 | Value of the first source register |
| rt_val | input | 32 | Value of the second source register |
| pc | output | 32 | Address of the instruction to fetch |
| slot_pend | output | 1 | A target is owed after the delay slot retires |
| slot_tgt | output | 32 | The owed target |
| squash | output | 1 | The current retire annuls its delay slot |
| bad_op | output | 1 | The presented opcode is not supported |

## Verification
The bench builds the default instance, which has the likely branch enabled, 32-bit addresses, a 16-bit offset and a 26-bit jump index. A small retire model fetches from a program image at the DUT's own `pc` and applies OR-immediate writes to a register model. As a result, an annulled slot appears as a register bit pattern that never changes, while an executed slot ORs its bits in. A second instance built with `LIKELY_EN` = 0 shares the same stimulus. This brings the removed-variant decode and its fall-through within reach of a check. Negative offsets and a jump whose index lands in the boot region exercise the sign extension and the concatenation of the upper PC bits.

// File: rtl/npc_pkg.sv
package npc_pkg;
   localparam logic [5:0] OPC_SPECIAL = 6'h00;
   localparam logic [5:0] OPC_J       = 6'h02;
   localparam logic [5:0] OPC_JAL     = 6'h03;
   localparam logic [5:0] OPC_BEQ     = 6'h04;
   localparam logic [5:0] OPC_BNE     = 6'h05;
   localparam logic [5:0] OPC_BEQL    = 6'h14;
   localparam logic [5:0] OPC_LW      = 6'h23;
   localparam logic [5:0] OPC_SW      = 6'h2B;

   typedef enum logic [2:0] {
      FL_SEQ,
      FL_BEQ,
      FL_BNE,
      FL_BEQL,
      FL_JUMP
   } flow_e;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
   import npc_pkg::*;
#(
   parameter int LIKELY_EN = 1
) (
   input  logic [5:0] op,
   output flow_e      flow,
   output logic       legal
);
   logic likely_ok;

   generate
      if (LIKELY_EN != 0) begin : g_likely
         assign likely_ok = 1'b1;
      end else begin : g_no_likely
         assign likely_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      flow  = FL_SEQ;
      legal = 1'b0;
      case (op) inside
         OPC_SPECIAL, OPC_LW, OPC_SW: legal = 1'b1;
         [6'h08:6'h0F]:               legal = 1'b1;
         OPC_J, OPC_JAL: begin
            flow  = FL_JUMP;
            legal = 1'b1;
         end
         OPC_BEQ: begin
            flow  = FL_BEQ;
            legal = 1'b1;
         end
         OPC_BNE: begin
            flow  = FL_BNE;
            legal = 1'b1;
         end
         OPC_BEQL: begin
            flow  = likely_ok ? FL_BEQL : FL_SEQ;
            legal = likely_ok;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/npc_target.sv
module npc_target #(
   parameter int XLEN  = 32,
   parameter int OFF_W = 16,
   parameter int IDX_W = 26
) (
   input  logic [XLEN-1:0]  pc,
   input  logic [IDX_W-1:0] idx,
   output logic [XLEN-1:0]  seq4,
   output logic [XLEN-1:0]  seq8,
   output logic [XLEN-1:0]  br_tgt,
   output logic [XLEN-1:0]  j_tgt
);
   localparam int EXT_W = XLEN - OFF_W - 2;
   localparam int TOP_W = XLEN - IDX_W - 2;
   localparam logic [XLEN-1:0] STEP4 = XLEN'(4);
   localparam logic [XLEN-1:0] STEP8 = XLEN'(8);

   logic [XLEN-1:0] disp;

   assign seq4   = pc + STEP4;
   assign seq8   = pc + STEP8;
   assign disp   = {{EXT_W{idx[OFF_W-1]}}, idx[OFF_W-1:0], 2'b00};
   assign br_tgt = seq4 + disp;
   assign j_tgt  = {seq4[XLEN-1 -: TOP_W], idx, 2'b00};
endmodule

// File: rtl/npc_state.sv
module npc_state
   import npc_pkg::*;
#(
   parameter int              XLEN     = 32,
   parameter logic [XLEN-1:0] BOOT_VEC = 32'hBFC00000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            retire,
   input  flow_e           flow,
   input  logic            eq,
   input  logic [XLEN-1:0] seq4,
   input  logic [XLEN-1:0] seq8,
   input  logic [XLEN-1:0] br_tgt,
   input  logic [XLEN-1:0] j_tgt,
   output logic [XLEN-1:0] pc,
   output logic            pend,
   output logic [XLEN-1:0] tgt,
   output logic            squash
);
   localparam logic [XLEN-1:0] STEP4 = XLEN'(4);
   localparam logic [XLEN-1:0] STEP8 = XLEN'(8);

   logic            take;
   logic            skip;
   logic [XLEN-1:0] nxt_tgt;

   always_comb begin
      take = 1'b0;
      case (flow)
         FL_BEQ, FL_BEQL: take = eq;
         FL_BNE:          take = !eq;
         FL_JUMP:         take = 1'b1;
         default:         take = 1'b0;
      endcase
      skip    = (flow == FL_BEQL) && !eq;
      nxt_tgt = (flow == FL_JUMP) ? j_tgt : br_tgt;
   end

   assign squash = retire && !pend && skip;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc   <= BOOT_VEC;
         pend <= 1'b0;
         tgt  <= '0;
      end else if (retire) begin
         if (pend) begin
            pc   <= tgt;
            pend <= 1'b0;
         end else if (take) begin
            pc   <= seq4;
            pend <= 1'b1;
            tgt  <= nxt_tgt;
         end else if (skip) begin
            pc <= seq8;
         end else begin
            pc <= seq4;
         end
      end
   end

   a_r3_taken_arms: assert property (@(posedge clk) disable iff (!rst_n)
      (retire && !pend && take) |=> (pend && pc == $past(pc) + STEP4));

   a_r5_slot_redirect: assert property (@(posedge clk) disable iff (!rst_n)
      (retire && pend) |=> (!pend && pc == $past(tgt)));

   a_r6_annul_skip: assert property (@(posedge clk) disable iff (!rst_n)
      squash |=> (!pend && pc == $past(pc) + STEP8));

   a_r7_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
      (retire && !pend && !take && !squash) |=> (!pend && pc == $past(pc) + STEP4));

   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !retire |=> ($stable(pc) && $stable(pend) && $stable(tgt)));
endmodule

// File: rtl/dslot_npc_seq.sv
module dslot_npc_seq
   import npc_pkg::*;
#(
   parameter int              XLEN      = 32,
   parameter int              OFF_W     = 16,
   parameter int              IDX_W     = 26,
   parameter int              LIKELY_EN = 1,
   parameter logic [XLEN-1:0] BOOT_VEC  = 32'hBFC00000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            retire,
   input  logic [31:0]     instr,
   input  logic [XLEN-1:0] rs_val,
   input  logic [XLEN-1:0] rt_val,
   output logic [XLEN-1:0] pc,
   output logic            slot_pend,
   output logic [XLEN-1:0] slot_tgt,
   output logic            squash,
   output logic            bad_op
);
   generate
      if (IDX_W + 6 != 32) begin : g_bad_idx
         $error("opcode field must sit directly above the jump index");
      end
      if (XLEN < IDX_W + 3) begin : g_bad_xlen
         $error("address width too small for the jump index");
      end
      if (OFF_W > IDX_W) begin : g_bad_off
         $error("branch offset must fit within the jump index field");
      end
   endgenerate

   flow_e           flow;
   logic            legal;
   logic            eq;
   logic [XLEN-1:0] seq4, seq8, br_tgt, j_tgt;

   assign eq     = (rs_val == rt_val);
   assign bad_op = !legal;

   npc_decode #(.LIKELY_EN(LIKELY_EN)) u_dec (
      .op    (instr[31:26]),
      .flow  (flow),
      .legal (legal)
   );

   npc_target #(.XLEN(XLEN), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_tgt (
      .pc     (pc),
      .idx    (instr[IDX_W-1:0]),
      .seq4   (seq4),
      .seq8   (seq8),
      .br_tgt (br_tgt),
      .j_tgt  (j_tgt)
   );

   npc_state #(.XLEN(XLEN), .BOOT_VEC(BOOT_VEC)) u_st (
      .clk    (clk),
      .rst_n  (rst_n),
      .retire (retire),
      .flow   (flow),
      .eq     (eq),
      .seq4   (seq4),
      .seq8   (seq8),
      .br_tgt (br_tgt),
      .j_tgt  (j_tgt),
      .pc     (pc),
      .pend   (slot_pend),
      .tgt    (slot_tgt),
      .squash (squash)
   );
endmodule

// File: tb/tb_dslot_npc_seq.sv
`timescale 1ns/1ps
module tb_dslot_npc_seq;
   localparam logic [31:0] BOOT = 32'hBFC00000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        retire = 1'b0;
   logic [31:0] instr = '0;
   logic [31:0] rs_val = '0;
   logic [31:0] rt_val = '0;
   logic [31:0] pc, slot_tgt, pc_nl, tgt_nl;
   logic        slot_pend, squash, bad_op, pend_nl, sq_nl, bad_nl;

   int errors = 0;
   int checks = 0;
   logic [31:0] mem [0:15];
   logic [31:0] regs [0:31];
   logic        sq_seen;

   always #10 clk = ~clk;

   dslot_npc_seq dut (
      .clk(clk), .rst_n(rst_n), .retire(retire), .instr(instr),
      .rs_val(rs_val), .rt_val(rt_val), .pc(pc), .slot_pend(slot_pend),
      .slot_tgt(slot_tgt), .squash(squash), .bad_op(bad_op)
   );

   dslot_npc_seq #(.LIKELY_EN(0)) dut_nl (
      .clk(clk), .rst_n(rst_n), .retire(retire), .instr(instr),
      .rs_val(rs_val), .rt_val(rt_val), .pc(pc_nl), .slot_pend(pend_nl),
      .slot_tgt(tgt_nl), .squash(sq_nl), .bad_op(bad_nl)
   );

   function automatic logic [31:0] enc(input logic [5:0] op, input int rs, input int rt,
                                       input logic [15:0] imm);
      return {op, 5'(rs), 5'(rt), imm};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n  = 1'b0;
      retire = 1'b0;
      for (int i = 0; i < 16; i++) mem[i] = 32'h0;
      for (int i = 0; i < 32; i++) regs[i] = 32'h0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Retire model: fetch at the DUT's pc, read operands, retire, apply OR-immediate.
   task automatic run_one();
      logic [31:0] w;
      @(negedge clk);
      w      = mem[(pc - BOOT) >> 2];
      instr  = w;
      rs_val = regs[w[25:21]];
      rt_val = regs[w[20:16]];
      retire = 1'b1;
      #1 sq_seen = squash;
      @(posedge clk);
      #1 retire = 1'b0;
      if (w[31:26] == 6'h0D && w[20:16] != 5'd0)
         regs[w[20:16]] = regs[w[25:21]] | {16'h0, w[15:0]};
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      @(posedge clk);
      #1;
      chk("R1 pc during reset", pc, BOOT);
      do_reset();
      #1;
      chk("R1 pc after reset", pc, BOOT);
      chk("R1 pending after reset", {31'h0, slot_pend}, 32'h0);
      chk("R1 squash idle", {31'h0, squash}, 32'h0);
   endtask

   task automatic t_decode();
      do_reset();
      instr = enc(6'h3F, 0, 0, 16'h0); #1;
      chk("R2 op 3F unsupported", {31'h0, bad_op}, 32'h1);
      instr = enc(6'h0D, 0, 0, 16'h0); #1;
      chk("R2 op 0D accepted", {31'h0, bad_op}, 32'h0);
      instr = enc(6'h14, 0, 0, 16'h0); #1;
      chk("R2 op 14 accepted", {31'h0, bad_op}, 32'h0);
      chk("R9 op 14 unsupported without likely", {31'h0, bad_nl}, 32'h1);
      instr = enc(6'h05, 0, 0, 16'h0); #1;
      chk("R2 op 05 accepted", {31'h0, bad_op}, 32'h0);
   endtask

   task automatic t_likely_taken();
      do_reset();
      regs[8] = 32'h5; regs[9] = 32'h5; regs[13] = 32'hBEEF0000;
      mem[0] = enc(6'h14, 8, 9, 16'd3);
      mem[1] = enc(6'h0D, 13, 13, 16'h00AD);
      mem[2] = enc(6'h0D, 14, 14, 16'h1111);
      mem[4] = enc(6'h0D, 14, 14, 16'hCAFE);
      run_one();
      chk("R3 likely taken pc", pc, BOOT + 4);
      chk("R3 likely taken pend", {31'h0, slot_pend}, 32'h1);
      chk("R3 likely taken target", slot_tgt, BOOT + 16);
      chk("R3 likely taken no squash", {31'h0, sq_seen}, 32'h0);
      run_one();
      chk("R5 redirect pc", pc, BOOT + 16);
      chk("R5 pend cleared", {31'h0, slot_pend}, 32'h0);
      chk("R3 slot executed", regs[13], 32'hBEEF00AD);
      run_one();
      chk("R5 target instr ran", regs[14], 32'h0000CAFE);
   endtask

   task automatic t_likely_not_taken();
      do_reset();
      regs[10] = 32'h1; regs[11] = 32'h2; regs[13] = 32'hBEEF0000;
      mem[0] = enc(6'h14, 10, 11, 16'd3);
      mem[1] = enc(6'h0D, 13, 13, 16'h0CAB);
      mem[2] = enc(6'h0D, 15, 15, 16'h2222);
      run_one();
      chk("R6 squash strobe", {31'h0, sq_seen}, 32'h1);
      chk("R6 pc skips slot", pc, BOOT + 8);
      chk("R6 no pending", {31'h0, slot_pend}, 32'h0);
      run_one();
      chk("R6 slot never wrote", regs[13], 32'hBEEF0000);
      chk("R6 landed past slot", regs[15], 32'h00002222);
      chk("R6 next pc", pc, BOOT + 12);
   endtask

   task automatic t_beq_not_taken();
      do_reset();
      regs[10] = 32'h1; regs[11] = 32'h2; regs[13] = 32'hBABE0000;
      mem[0] = enc(6'h04, 10, 11, 16'd3);
      mem[1] = enc(6'h0D, 13, 13, 16'h0CAB);
      run_one();
      chk("R7 no squash", {31'h0, sq_seen}, 32'h0);
      chk("R7 pc+4", pc, BOOT + 4);
      chk("R7 no pending", {31'h0, slot_pend}, 32'h0);
      run_one();
      chk("R7 slot executed", regs[13], 32'hBABE0CAB);
      chk("R7 fall through", pc, BOOT + 8);
   endtask

   task automatic t_jump_bne_back();
      logic [31:0] dst;
      do_reset();
      regs[10] = 32'h1; regs[11] = 32'h2;
      dst = BOOT + 24;
      mem[0] = {6'h02, dst[27:2]};
      mem[1] = enc(6'h0D, 24, 24, 16'h0001);
      mem[6] = enc(6'h05, 10, 11, 16'hFFFA);
      mem[7] = enc(6'h0D, 25, 25, 16'h0002);
      run_one();
      chk("R4 jump pend", {31'h0, slot_pend}, 32'h1);
      chk("R4 jump target", slot_tgt, {BOOT[31:28], dst[27:2], 2'b00});
      run_one();
      chk("R4 jump lands", pc, BOOT + 24);
      chk("R4 jump slot ran", regs[24], 32'h1);
      run_one();
      chk("R3 bne negative target", slot_tgt, BOOT + 4);
      run_one();
      chk("R3 bne redirect", pc, BOOT + 4);
      chk("R3 bne slot ran", regs[25], 32'h2);
   endtask

   task automatic t_slot_branch_and_hold();
      do_reset();
      regs[8] = 32'h7; regs[9] = 32'h7; regs[10] = 32'h1; regs[11] = 32'h2;
      mem[0] = enc(6'h04, 8, 9, 16'd3);
      mem[1] = enc(6'h04, 8, 9, 16'd7);
      run_one();
      run_one();
      chk("R5 slot branch ignored pc", pc, BOOT + 16);
      chk("R5 slot branch no pend", {31'h0, slot_pend}, 32'h0);
      @(negedge clk);
      instr = enc(6'h14, 10, 11, 16'd3);
      rs_val = 32'h1; rt_val = 32'h2; retire = 1'b0;
      #1 chk("R8 squash low without retire", {31'h0, squash}, 32'h0);
      @(posedge clk); #1;
      chk("R8 pc holds", pc, BOOT + 16);
      chk("R8 pend holds", {31'h0, slot_pend}, 32'h0);
   endtask

   task automatic t_no_likely();
      do_reset();
      regs[10] = 32'h1; regs[11] = 32'h2;
      mem[0] = enc(6'h14, 10, 11, 16'd3);
      run_one();
      chk("R9 pc steps by 4", pc_nl, BOOT + 4);
      chk("R9 no pending", {31'h0, pend_nl}, 32'h0);
   endtask

   initial begin
      t_reset();
      t_decode();
      t_likely_taken();
      t_likely_not_taken();
      t_beq_not_taken();
      t_jump_bne_back();
      t_slot_branch_and_hold();
      t_no_likely();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog all act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule